// File: doc/BRIEF.md
# Three-Tap FIR Filter with One Cutset Pipeline Stage

This block filters a stream of signed samples with three fixed taps. It computes y(n) = A·x(n) + B·x(n-1) + C·x(n-2) and accepts at most one sample per clock. A two-entry delay line holds the two previous samples.

One register stage is placed across a feed-forward cutset of the filter graph. The first stage forms the partial sum A·x(n) + B·x(n-1) and registers it. In the same cycle it registers the product C·x(n-2). The second stage adds the two registered terms without any further register. The longest combinational path is therefore one multiplier plus one adder, where the plain direct form needs one multiplier plus two adders. The cost is one extra clock of latency.

Coefficients are expected to be held steady while samples stream. The result keeps full precision, with no rounding and no saturation.

Top module: `fir3_cutset_pipe`

## Requirements
- R1: When a valid sample x(n) is accepted on a rising edge, out_sum shows A·x(n) + B·x(n-1) + C·x(n-2) after that edge. Here x(n-1) and x(n-2) are the two previously accepted samples.
- R2: out_valid is high in the cycle that follows a clock edge at which in_valid was high, and low in the cycle that follows an edge at which in_valid was low.
- R3: A synchronous reset clears out_sum to 0 and out_valid to 0. It also empties the history, so the first two outputs after reset use zero for the missing older samples.
- R4: An edge at which in_valid is low changes neither the delay line nor the pipeline registers. out_sum keeps its value, and the next valid sample still sees the same two older samples.
- R5: Samples and coefficients are signed 16-bit two's-complement values. out_sum is a signed 34-bit value that never wraps, including when every input is -32768.
- R6: Both registers on the cutset advance on the same accepted sample. The C·x(n-2) term therefore always pairs with the A and B terms of the same output, even when invalid cycles fall between samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | High when in_sample holds a new sample |
| in_sample | input | 16 | Signed input sample |
| coef_a | input | 16 | Signed tap weight for the newest sample |
| coef_b | input | 16 | Signed tap weight for the previous sample |
| coef_c | input | 16 | Signed tap weight for the sample two back |
| out_valid | output | 1 | High when out_sum holds a new result |
| out_sum | output | 34 | Signed filtered result, full precision |

## Verification
An impulse with distinct weights moves through the three taps one at a time. This shows whether each weight meets the right sample age, and whether reset left the history at zero. Long random streams, with random valid gaps and random coefficient sets, separate a correct cutset from one where a single edge stalls or advances on its own: a misaligned C term shows up only when gaps are present. Extreme operands, all -32768 or mixed with 32767, expose any product or sum narrower than full precision.

// File: rtl/fir3_cutset_pipe.sv
module fir3_cutset_pipe #(
  parameter int DW = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic signed [DW-1:0]   in_sample,
  input  logic signed [DW-1:0]   coef_a,
  input  logic signed [DW-1:0]   coef_b,
  input  logic signed [DW-1:0]   coef_c,
  output logic                   out_valid,
  output logic signed [2*DW+1:0] out_sum
);
  localparam int PW = 2 * DW;
  localparam int SW = PW + 1;
  localparam int OW = PW + 2;

  logic signed [DW-1:0] tap1, tap2;
  logic signed [PW-1:0] prod_a, prod_b, prod_c;
  logic signed [SW-1:0] near_sum;
  logic signed [PW-1:0] far_prod;
  logic                 vld_q;

  assign prod_a = PW'(coef_a) * PW'(in_sample);
  assign prod_b = PW'(coef_b) * PW'(tap1);
  assign prod_c = PW'(coef_c) * PW'(tap2);

  always_ff @(posedge clk) begin
    if (rst) begin
      tap1     <= '0;
      tap2     <= '0;
      near_sum <= '0;
      far_prod <= '0;
      vld_q    <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        tap1     <= in_sample;
        tap2     <= tap1;
        near_sum <= SW'(prod_a) + SW'(prod_b);
        far_prod <= prod_c;
      end
    end
  end

  assign out_sum   = OW'(near_sum) + OW'(far_prod);
  assign out_valid = vld_q;

  p_reset_clear_r3: assert property (@(posedge clk)
    rst |=> (out_sum == '0 && !out_valid));

  p_valid_lag_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_lag_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_sum));

  p_single_tap_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && coef_b == '0 && coef_c == '0) |=>
      out_sum == $past(coef_a) * $past(in_sample));
endmodule

// File: tb/sim_fir3_cutset_pipe.sv
module sim_fir3_cutset_pipe;
  logic               clk = 1'b0;
  logic               rst;
  logic               in_valid;
  logic signed [15:0] in_sample, coef_a, coef_b, coef_c;
  logic               out_valid;
  logic signed [33:0] out_sum;

  int  n_cmp = 0;
  int  n_bad = 0;
  longint h1, h2, last;
  bit  done = 0;

  always #2.5 clk = ~clk;

  fir3_cutset_pipe u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c),
    .out_valid(out_valid), .out_sum(out_sum)
  );

  function automatic longint model(longint a, longint b, longint c,
                                   longint x0, longint x1, longint x2);
    return a * x0 + b * x1 + c * x2;
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; in_sample = '0;
    @(negedge clk);
    rst = 1'b0;
    h1 = 0; h2 = 0; last = 0;
    check("R3 out_valid after reset", longint'(out_valid), 0);
    check("R3 out_sum after reset", longint'(out_sum), 0);
  endtask

  task automatic step(bit v, logic signed [15:0] x, string req);
    longint exp;
    @(negedge clk);
    in_valid = v; in_sample = x;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R2 valid"}, longint'(out_valid), longint'(v));
    if (v) begin
      exp = model(coef_a, coef_b, coef_c, x, h1, h2);
      h2 = h1; h1 = x; last = exp;
      check({req, " R1 sum"}, longint'(out_sum), exp);
    end else begin
      check({req, " R4 hold"}, longint'(out_sum), last);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; in_valid = 1'b0; in_sample = '0;
    coef_a = 16'sd3; coef_b = -16'sd5; coef_c = 16'sd7;
    do_reset();

    step(1, 16'sd1, "R3 impulse first");
    step(1, 16'sd0, "R1 impulse tap b");
    step(0, 16'sd99, "R4 gap");
    step(1, 16'sd0, "R1 impulse tap c");
    step(1, 16'sd0, "R1 impulse cleared");

    coef_a = -16'sd32768; coef_b = -16'sd32768; coef_c = -16'sd32768;
    do_reset();
    step(1, -16'sd32768, "R5 extreme");
    step(1, -16'sd32768, "R5 extreme");
    step(1, -16'sd32768, "R5 extreme max");
    coef_b = 16'sd32767;
    step(1, 16'sd32767, "R5 mixed");

    for (int s = 0; s < 8; s++) begin
      coef_a = 16'($urandom); coef_b = 16'($urandom); coef_c = 16'($urandom);
      do_reset();
      for (int i = 0; i < 200; i++)
        step(($urandom % 3) != 0, 16'($urandom), "R6 random stream");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule